// File: doc/BRIEF.md
# Frequency-Domain Complex Multiply-Accumulate

This block performs the multiply-then-sum step of an external product, between the forward and inverse Fourier transforms. It takes a stream of transformed samples from a decomposed ciphertext and a stream of transformed key samples. For every frequency bin it forms the complex product of the two samples. It sums these products over several decomposition terms and hands the summed spectrum on to the inverse transform. Each cycle carries `LANES` complex samples. A polynomial's bins take `BEATS` beats, so one pass over all bins is one decomposition term.

The operands are signed 64-bit fixed point with 48 fractional bits (Q15.48). The caller keeps their magnitudes below about 20,800. Each product is kept exact at 96 fractional bits, and the running sums are stored per bin and per lane. On the last term the sum is rounded to nearest and narrowed to signed 64-bit with 33 fractional bits (Q30.33). A result that does not fit the output range is clamped to the nearest end of that range. A `first` flag marks the pass of the first term, which starts a fresh sum. A `last` flag marks the pass of the final term, whose beats produce outputs.

Top module: `spec_mac`

## Requirements
- R1: For lane operands a and b, the real part is a_re*b_re − a_im*b_im and the imaginary part is a_re*b_im + a_im*b_re. Both are computed exactly at 96 fractional bits. Operands are Q15.48 two's complement.
- R2: A beat accepted with `in_first`=1 discards the stored sum for its bin and lane. The new sum is that beat's product alone, so nothing carries over from an earlier polynomial.
- R3: A beat accepted with `in_first`=0 adds its product to the sum stored for the same beat position and lane. Each beat position keeps its own sum, which never overflows for up to `MAX_TERMS` terms.
- R4: `out_valid` is 1 in exactly the cycle after a beat accepted with `in_valid`=1 and `in_last`=1, and 0 at all other times. Outputs keep their value between results.
- R5: The output is the sum at 96 fractional bits plus 2^62, shifted right arithmetically by 63, giving Q30.33. A tie rounds toward +infinity: a sum of exactly +2^62 gives 1 and a sum of exactly −2^62 gives 0.
- R6: A rounded value above 2^63−1 gives 0x7FFF_FFFF_FFFF_FFFF. A rounded value below −2^63 gives 0x8000_0000_0000_0000.
- R7: The bin position advances only on beats with `in_valid`=1 and wraps to 0 after `BEATS` beats. Idle cycles change neither the position nor any stored sum.
- R8: Lane l occupies bits [64l+63 : 64l] of every data port. Lanes do not affect each other.
- R9: While and right after reset, `out_valid` is 0, both output words are 0, and the bin position is 0.
- R10: A beat with both `in_first` and `in_last` set outputs the rounded value of its own product alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present |
| in_first | input | 1 | Beat belongs to the first term of the sum |
| in_last | input | 1 | Beat belongs to the final term; produces output |
| in_a_re | input | LANES*64 | Ciphertext spectrum, real parts, Q15.48 |
| in_a_im | input | LANES*64 | Ciphertext spectrum, imaginary parts, Q15.48 |
| in_b_re | input | LANES*64 | Key spectrum, real parts, Q15.48 |
| in_b_im | input | LANES*64 | Key spectrum, imaginary parts, Q15.48 |
| out_valid | output | 1 | Output beat present |
| out_re | output | LANES*64 | Summed spectrum, real parts, Q30.33 |
| out_im | output | LANES*64 | Summed spectrum, imaginary parts, Q30.33 |

## Verification
A bin position that has slipped shows up at the first output beat after the slip. The sum of another bin appears there, in a polynomial whose beats all carry different operands. A stale sum that the first flag failed to clear shows up in the very next polynomial's outputs. A wrong rounding or clamping boundary appears only on the exact tie and out-of-range sums, so these are driven as directed cases with literal expected words. An error in the exact product or the summing shows in the low bits of every output beat one cycle after the final term.

// File: rtl/spec_mac_pkg.sv
package spec_mac_pkg;
  localparam int DW       = 64;
  localparam int IN_FRAC  = 48;
  localparam int OUT_FRAC = 33;
  localparam int PW       = 2 * DW;
  localparam int WIDE_W   = 160;
  localparam int RSHIFT   = 2 * IN_FRAC - OUT_FRAC;

  typedef logic signed [DW-1:0]     word_t;
  typedef logic signed [PW-1:0]     prod_t;
  typedef logic signed [WIDE_W-1:0] wide_t;

  localparam word_t WORD_MAX = {1'b0, {(DW-1){1'b1}}};
  localparam word_t WORD_MIN = {1'b1, {(DW-1){1'b0}}};

  // real part of (ar + j ai)(br + j bi), exact
  function automatic wide_t cmul_re(word_t ar, word_t ai, word_t br, word_t bi);
    prod_t p1, p2;
    p1 = prod_t'(ar) * prod_t'(br);
    p2 = prod_t'(ai) * prod_t'(bi);
    return wide_t'(p1) - wide_t'(p2);
  endfunction

  // imaginary part, exact
  function automatic wide_t cmul_im(word_t ar, word_t ai, word_t br, word_t bi);
    prod_t p1, p2;
    p1 = prod_t'(ar) * prod_t'(bi);
    p2 = prod_t'(ai) * prod_t'(br);
    return wide_t'(p1) + wide_t'(p2);
  endfunction

  function automatic wide_t round_shift(wide_t x);
    wide_t t;
    t = x + (wide_t'(1) <<< (RSHIFT - 1));
    return t >>> RSHIFT;
  endfunction

  function automatic logic over_hi(wide_t x);
    return round_shift(x) > wide_t'(WORD_MAX);
  endfunction

  function automatic logic over_lo(wide_t x);
    return round_shift(x) < wide_t'(WORD_MIN);
  endfunction

  // round to nearest (ties up), then clamp to the output word
  function automatic word_t requant(wide_t x);
    wide_t s;
    s = round_shift(x);
    if (over_hi(x))      return WORD_MAX;
    else if (over_lo(x)) return WORD_MIN;
    else                 return word_t'(s);
  endfunction
endpackage

// File: rtl/spec_mac_beat.sv
module spec_mac_beat #(
  parameter int BEATS = 4,
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [IDX_W-1:0] idx
);
  logic at_end;
  assign at_end = (idx == IDX_W'(BEATS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)      idx <= '0;
    else if (step)   idx <= at_end ? '0 : idx + 1'b1;
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    idx <= IDX_W'(BEATS - 1)); // R7
  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_end) |=> (idx == '0)); // R7
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(idx)); // R7
endmodule

// File: rtl/spec_mac_lane.sv
module spec_mac_lane
  import spec_mac_pkg::*;
#(
  parameter int BEATS = 4,
  parameter int ACC_W = 132,
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat_en,
  input  logic             first,
  input  logic             last,
  input  logic [IDX_W-1:0] idx,
  input  word_t            ar,
  input  word_t            ai,
  input  word_t            br,
  input  word_t            bi,
  output word_t            res_re,
  output word_t            res_im
);
  logic signed [ACC_W-1:0] acc_re [BEATS];
  logic signed [ACC_W-1:0] acc_im [BEATS];

  wide_t prod_re, prod_im, base_re, base_im, sum_re, sum_im;
  logic signed [ACC_W-1:0] next_re, next_im;
  logic sat_hi_re, sat_lo_re, sat_hi_im, sat_lo_im;

  assign prod_re = cmul_re(ar, ai, br, bi);
  assign prod_im = cmul_im(ar, ai, br, bi);
  assign base_re = first ? '0 : wide_t'(acc_re[idx]);
  assign base_im = first ? '0 : wide_t'(acc_im[idx]);
  assign sum_re  = base_re + prod_re;
  assign sum_im  = base_im + prod_im;
  assign next_re = ACC_W'(sum_re);
  assign next_im = ACC_W'(sum_im);

  assign sat_hi_re = over_hi(sum_re);
  assign sat_lo_re = over_lo(sum_re);
  assign sat_hi_im = over_hi(sum_im);
  assign sat_lo_im = over_lo(sum_im);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < BEATS; i++) begin
        acc_re[i] <= '0;
        acc_im[i] <= '0;
      end
      res_re <= '0;
      res_im <= '0;
    end else if (beat_en) begin
      acc_re[idx] <= next_re;
      acc_im[idx] <= next_im;
      if (last) begin
        res_re <= requant(sum_re);
        res_im <= requant(sum_im);
      end
    end
  end

  AST_ACC_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    beat_en |-> (sum_re == wide_t'(next_re) && sum_im == wide_t'(next_im))); // R3
  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_en && last && sat_hi_re) |=> (res_re == WORD_MAX)); // R6
  AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_en && last && sat_lo_im) |=> (res_im == WORD_MIN)); // R6
  AST_SAT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sat_hi_re && sat_lo_re) && !(sat_hi_im && sat_lo_im)); // R6
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(beat_en && last) |=> ($stable(res_re) && $stable(res_im))); // R4
endmodule

// File: rtl/spec_mac.sv
module spec_mac
  import spec_mac_pkg::*;
#(
  parameter int LANES     = 2,
  parameter int BEATS     = 4,
  parameter int MAX_TERMS = 8,
  localparam int IDX_W = (BEATS > 1) ? $clog2(BEATS) : 1,
  localparam int ACC_W = PW + 1 + ((MAX_TERMS > 1) ? $clog2(MAX_TERMS) : 1),
  localparam int BUS_W = LANES * DW
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_first,
  input  logic             in_last,
  input  logic [BUS_W-1:0] in_a_re,
  input  logic [BUS_W-1:0] in_a_im,
  input  logic [BUS_W-1:0] in_b_re,
  input  logic [BUS_W-1:0] in_b_im,
  output logic             out_valid,
  output logic [BUS_W-1:0] out_re,
  output logic [BUS_W-1:0] out_im
);
  logic [IDX_W-1:0] beat_idx;

  spec_mac_beat #(.BEATS(BEATS)) u_beat (
    .clk   (clk),
    .rst_n (rst_n),
    .step  (in_valid),
    .idx   (beat_idx)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    word_t lane_re, lane_im;
    spec_mac_lane #(.BEATS(BEATS), .ACC_W(ACC_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .beat_en (in_valid),
      .first   (in_first),
      .last    (in_last),
      .idx     (beat_idx),
      .ar      (word_t'(in_a_re[l*DW +: DW])),
      .ai      (word_t'(in_a_im[l*DW +: DW])),
      .br      (word_t'(in_b_re[l*DW +: DW])),
      .bi      (word_t'(in_b_im[l*DW +: DW])),
      .res_re  (lane_re),
      .res_im  (lane_im)
    );
    assign out_re[l*DW +: DW] = lane_re;
    assign out_im[l*DW +: DW] = lane_im;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid && in_last;
  end

  AST_VALID_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && in_last)); // R4
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_last) |=> out_valid); // R4
endmodule

// File: tb/tb_spec_mac.sv
`timescale 1ns/1ps
module tb_spec_mac;
  localparam int LANES = 2;
  localparam int BEATS = 4;
  localparam int MAXT  = 8;
  localparam int W     = 64;

  // scenario table: terms, seed, right-shift of operands, idle gaps
  localparam int NSCN = 7;
  localparam int SC_TERMS [NSCN] = '{1, 3, 8, 2, 5, 4, 6};
  localparam int SC_SEED  [NSCN] = '{11, 22, 33, 44, 55, 66, 77};
  localparam int SC_SHIFT [NSCN] = '{2, 3, 2, 5, 4, 2, 2};
  localparam int SC_GAP   [NSCN] = '{0, 0, 0, 1, 0, 1, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [LANES*W-1:0] in_a_re = '0, in_a_im = '0, in_b_re = '0, in_b_im = '0;
  logic out_valid;
  logic [LANES*W-1:0] out_re, out_im;

  int n_chk = 0;
  int n_bad = 0;

  logic signed [159:0] m_re [LANES][BEATS];
  logic signed [159:0] m_im [LANES][BEATS];

  always #4 clk = ~clk;

  spec_mac #(.LANES(LANES), .BEATS(BEATS), .MAX_TERMS(MAXT)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_a_re(in_a_re), .in_a_im(in_a_im),
    .in_b_re(in_b_re), .in_b_im(in_b_im), .out_valid(out_valid),
    .out_re(out_re), .out_im(out_im));

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // rounding by remainder test, then clamp
  function automatic logic [63:0] model_out(logic signed [159:0] x);
    logic signed [159:0] q;
    q = x >>> 63;
    if (x[62]) q = q + 1;
    if (q > 160'sh7FFF_FFFF_FFFF_FFFF) return 64'h7FFF_FFFF_FFFF_FFFF;
    if (q < -160'sh8000_0000_0000_0000) return 64'h8000_0000_0000_0000;
    return q[63:0];
  endfunction

  function automatic logic signed [63:0] gen(int seed, int t, int b, int l, int k, int sh);
    logic [63:0] h;
    h = 64'(seed) * 64'h9E37_79B9_7F4A_7C15;
    h = h ^ {32'(t), 8'(b), 8'(l), 16'(k)};
    h = h * 64'hBF58_476D_1CE4_E5B9;
    h = h ^ (h >> 29);
    return $signed(h) >>> sh;
  endfunction

  task automatic step_and_check(input bit last_beat, input int b);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (last_beat) begin
      check(out_valid === 1'b1, "R4 valid after last", 64'(out_valid), 64'd1);
      for (int l = 0; l < LANES; l++) begin
        check(out_re[l*W +: W] === model_out(m_re[l][b]), "R1 R3 R5 R8 re",
              out_re[l*W +: W], model_out(m_re[l][b]));
        check(out_im[l*W +: W] === model_out(m_im[l][b]), "R1 R3 R5 R8 im",
              out_im[l*W +: W], model_out(m_im[l][b]));
      end
    end else begin
      check(out_valid === 1'b0, "R4 no valid before last", 64'(out_valid), 64'd0);
    end
  endtask

  task automatic run_pass(input int terms, input int seed, input int sh, input bit gap);
    for (int t = 0; t < terms; t++) begin
      for (int b = 0; b < BEATS; b++) begin
        in_valid = 1'b1;
        in_first = (t == 0);
        in_last  = (t == terms - 1);
        for (int l = 0; l < LANES; l++) begin
          logic signed [63:0] ar, ai, br, bi;
          logic signed [159:0] wr, wi;
          ar = gen(seed, t, b, l, 0, sh);
          ai = gen(seed, t, b, l, 1, sh);
          br = gen(seed, t, b, l, 2, sh);
          bi = gen(seed, t, b, l, 3, sh);
          in_a_re[l*W +: W] = ar;
          in_a_im[l*W +: W] = ai;
          in_b_re[l*W +: W] = br;
          in_b_im[l*W +: W] = bi;
          wr = 160'(ar) * 160'(br) - 160'(ai) * 160'(bi);
          wi = 160'(ar) * 160'(bi) + 160'(ai) * 160'(br);
          // R2: first term restarts the model sum
          m_re[l][b] = (t == 0) ? wr : m_re[l][b] + wr;
          m_im[l][b] = (t == 0) ? wi : m_im[l][b] + wi;
        end
        step_and_check(t == terms - 1, b);
        if (gap) begin
          // R7: idle cycle with junk operands must not disturb anything
          in_a_re = '1; in_b_re = '1; in_first = 1'b1; in_last = 1'b1;
          @(posedge clk);
          @(negedge clk);
          check(out_valid === 1'b0, "R7 idle no output", 64'(out_valid), 64'd0);
        end
      end
    end
  endtask

  // same operands on every lane and beat, literal expectation
  task automatic run_const(input int terms, input logic [63:0] ar, input logic [63:0] ai,
                           input logic [63:0] br, input logic [63:0] bi,
                           input logic [63:0] exp_re, input logic [63:0] exp_im,
                           input string req);
    for (int t = 0; t < terms; t++) begin
      for (int b = 0; b < BEATS; b++) begin
        in_valid = 1'b1;
        in_first = (t == 0);
        in_last  = (t == terms - 1);
        in_a_re = {LANES{ar}}; in_a_im = {LANES{ai}};
        in_b_re = {LANES{br}}; in_b_im = {LANES{bi}};
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if (t == terms - 1) begin
          for (int l = 0; l < LANES; l++) begin
            check(out_re[l*W +: W] === exp_re, req, out_re[l*W +: W], exp_re);
            check(out_im[l*W +: W] === exp_im, req, out_im[l*W +: W], exp_im);
          end
        end
      end
    end
  endtask

  localparam logic [63:0] BIG  = 64'd20000 << 48;
  localparam logic [63:0] NBIG = -(64'd20000 << 48);
  localparam logic [63:0] ONE  = 64'd1 << 48;
  localparam logic [63:0] HALF = 64'd1 << 14;

  initial begin : main
    in_a_re = '1; in_b_re = '1; in_valid = 1'b1; in_last = 1'b1;
    repeat (3) @(negedge clk);
    // R9: reset state, even with a beat presented during reset
    check(out_valid === 1'b0, "R9 reset valid", 64'(out_valid), 64'd0);
    check(out_re === '0, "R9 reset re", out_re[63:0], 64'd0);
    check(out_im === '0, "R9 reset im", out_im[63:0], 64'd0);
    in_valid = 1'b0; in_last = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R9 after reset", 64'(out_valid), 64'd0);

    for (int s = 0; s < NSCN; s++)
      run_pass(SC_TERMS[s], SC_SEED[s], SC_SHIFT[s], SC_GAP[s] != 0);

    // R5: exact ties, 2^14 * 2^48 = 2^62
    run_const(1, HALF, 64'd0, ONE, 64'd0, 64'd1, 64'd0, "R5 R10 positive tie");
    run_const(1, -HALF, 64'd0, ONE, 64'd0, 64'd0, 64'd0, "R5 R10 negative tie");
    run_const(1, HALF, HALF, ONE, 64'd0, 64'd1, 64'd1, "R5 tie im");
    // R6: 3 x 4e8 exceeds 2^30
    run_const(3, BIG, 64'd0, BIG, 64'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd0, "R6 clamp high");
    run_const(3, BIG, 64'd0, 64'd0, NBIG, 64'd0, 64'h8000_0000_0000_0000, "R6 clamp low");
    // R2: a fresh one-term polynomial after the clamped sums
    run_const(1, ONE, 64'd0, ONE, 64'd0, 64'd1 << 33, 64'd0, "R2 R10 fresh start");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule